// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry-in. It returns a 16-bit sum and a carry-out. It is purely combinational and has no clock. The width is split into equal groups. Each group forms per-bit generate terms (AND of the operand bits) and propagate terms (XOR of the operand bits). From these, each group builds its internal carries in flat two-level sum-of-products form. Each group also reports one group generate and one group propagate.

A second lookahead level takes the group generate/propagate pairs and the carry-in. It produces the carry into every group at once, so no carry ripples from one group to the next. Each sum bit is the XOR of that bit's propagate term and the carry into the bit.

Typical use is as the datapath adder of an arithmetic unit where the depth of the carry chain limits the cycle time.

Top module: `cla16`

## Requirements
- R1: For every input combination, the 17-bit value {cout, sum} equals a + b + cin taken as unsigned numbers.
- R2: When both operands are all ones and cin is 1, sum is all ones and cout is 1.
- R3: When a XOR b is all ones, meaning every bit propagates, cout equals cin. In that case sum is all ones when cin is 0 and all zeros when cin is 1.
- R4: When both operands are zero, sum equals cin zero-extended and cout is 0.
- R5: A carry that starts in bit 0 reaches cout when every higher bit propagates. Examples: a = 16'h0001 with b = 16'hFFFF gives sum 0 and cout 1. The same happens when a = 16'hFFFF, b = 0 and cin = 1.
- R6: When bit 15 of both a and b is 1, cout is 1 whatever the other inputs are.
- R7: The carry into each group equals the carry out of the sum of all lower bits plus cin. A carry that crosses a group boundary therefore appears in the next group's sum bits. For example, 16'h00FF + 16'h0001 gives 16'h0100 with cout 0.
- R8: Alternating-bit operands add correctly. For example, 16'hAAAA + 16'hAAAA + 0 gives sum 16'h5554 with cout 1, and 16'h5555 + 16'h5555 + 1 gives sum 16'hAAAB with cout 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The bench builds the adder with its default parameters: four groups of four bits each.

With that layout, the directed vectors reach every group boundary. They also cover the full-length propagate chain and the generate-only case in the top bit. Random vectors from a fixed seed spread generate and propagate patterns over all groups at once. The bound checker compares each second-level group carry against the carry of the matching lower partial sum.

// File: rtl/cla16.sv
module cla16 #(
  parameter int GROUP_W    = 4,
  parameter int NUM_GROUPS = 4,
  localparam int W = GROUP_W * NUM_GROUPS
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  // Flat lookahead: carry into position k from generate/propagate vectors.
  function automatic logic carry_at(input logic [W-1:0] gv, input logic [W-1:0] pv,
                                    input logic ci, input int k);
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int j = 0; j < k; j++) begin
      prod = gv[j];
      for (int m = j + 1; m < k; m++) prod = prod & pv[m];
      acc = acc | prod;
    end
    prod = ci;
    for (int m = 0; m < k; m++) prod = prod & pv[m];
    return acc | prod;
  endfunction

  logic [W-1:0]          bit_g, bit_p;
  logic [NUM_GROUPS-1:0] grp_g, grp_p;
  logic [NUM_GROUPS:0]   grp_c;

  assign bit_g = a & b;
  assign bit_p = a ^ b;

  for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_slice
    logic [GROUP_W-1:0] sg, sp, sc;
    assign sg = bit_g[gi*GROUP_W +: GROUP_W];
    assign sp = bit_p[gi*GROUP_W +: GROUP_W];

    always_comb begin
      for (int k = 0; k < GROUP_W; k++)
        sc[k] = carry_at(W'(sg), W'(sp), grp_c[gi], k);
    end

    assign grp_g[gi] = carry_at(W'(sg), W'(sp), 1'b0, GROUP_W);
    assign grp_p[gi] = &sp;
    assign sum[gi*GROUP_W +: GROUP_W] = sp ^ sc;
  end

  assign grp_c[0] = cin;
  for (genvar gk = 1; gk <= NUM_GROUPS; gk++) begin : g_top
    assign grp_c[gk] = carry_at(W'(grp_g), W'(grp_p), cin, gk);
  end

  assign cout = grp_c[NUM_GROUPS];

endmodule

module cla16_chk #(
  parameter int GROUP_W    = 4,
  parameter int NUM_GROUPS = 4,
  localparam int W = GROUP_W * NUM_GROUPS
) (
  input logic [W-1:0]        a,
  input logic [W-1:0]        b,
  input logic                cin,
  input logic [W-1:0]        sum,
  input logic                cout,
  input logic [NUM_GROUPS:0] grp_c
);

  logic [W:0] ref_total;
  assign ref_total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

  always_comb begin
    p_total_r1: assert ({cout, sum} == ref_total)
      else $error("R1 total mismatch");
    if (&(a ^ b)) begin
      p_prop_chain_r3: assert (cout == cin)
        else $error("R3 carry-out not equal to carry-in");
    end
    if (a[W-1] && b[W-1]) begin
      p_top_gen_r6: assert (cout)
        else $error("R6 top generate lost");
    end
    if (a == '0 && b == '0) begin
      p_zero_ops_r4: assert (sum == W'(cin) && !cout)
        else $error("R4 zero operands");
    end
    for (int k = 1; k <= NUM_GROUPS; k++) begin
      logic [W:0] mask;
      logic [W:0] part;
      mask = {(W+1){1'b1}} >> (W + 1 - k*GROUP_W);
      part = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{W{1'b0}}, cin};
      p_group_carry_r7: assert (grp_c[k] == part[k*GROUP_W])
        else $error("R7 group carry %0d wrong", k);
    end
  end

endmodule

bind cla16 cla16_chk #(.GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .grp_c(grp_c)
);

// File: tb/cla16_test.sv
module cla16_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] a, b, sum;
  logic        cin, cout;
  int n_checks = 0;
  int n_fail   = 0;

  cla16 uut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  function automatic logic [16:0] model(input logic [15:0] x, input logic [15:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {16'd0, c};
  endfunction

  task automatic check(input string req, input logic [15:0] x, input logic [15:0] y,
                       input logic c, input logic [16:0] expv);
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    n_checks++;
    if ({cout, sum} !== expv) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, x, y, c, {cout, sum}, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    check("R4", 16'h0000, 16'h0000, 1'b0, 17'h00000);
    check("R4", 16'h0000, 16'h0000, 1'b1, 17'h00001);
    check("R2", 16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF);
    check("R3", 16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF);
    check("R3", 16'hAAAA, 16'h5555, 1'b1, 17'h10000);
    check("R5", 16'h0001, 16'hFFFF, 1'b0, 17'h10000);
    check("R5", 16'hFFFF, 16'h0000, 1'b1, 17'h10000);
    check("R6", 16'h8000, 16'h8000, 1'b0, 17'h10000);
    check("R6", 16'hF123, 16'h8ABC, 1'b1, model(16'hF123, 16'h8ABC, 1'b1));
    check("R7", 16'h00FF, 16'h0001, 1'b0, 17'h00100);
    check("R7", 16'h000F, 16'h0000, 1'b1, 17'h00010);
    check("R7", 16'h0FFF, 16'h0000, 1'b1, 17'h01000);
    check("R8", 16'hAAAA, 16'hAAAA, 1'b0, 17'h15554);
    check("R8", 16'h5555, 16'h5555, 1'b1, 17'h0AAAB);
    begin
      int seed_use;
      seed_use = $urandom(32'd2024);
      for (int i = 0; i < 3000; i++) begin
        logic [15:0] x, y;
        logic        c;
        x = 16'($urandom);
        y = 16'($urandom);
        c = 1'($urandom);
        if (i % 8 == 0) y = ~x;
        check("R1", x, y, c, model(x, y, c));
      end
    end
    finish_run();
  end
endmodule